// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block is a small pool of waiting slots placed in front of one class of execution unit, for example the adders. Issue logic writes an operation into a free slot together with its two source operands. Each operand arrives either as a finished value or as the identifier of the slot that will later produce it. Slots that still lack an operand watch a single result broadcast bus. When the identifier on the bus matches, the slot copies the value and marks that operand as present.

Every cycle the array offers one slot whose two operands are both present to the execution unit. The unit accepts the offer with a grant. A granted slot stays reserved but is not offered again. It is released when the unit's own result appears on the broadcast bus under that slot's identifier. Each slot's identifier is fixed. The upper bits carry the unit class and the lower bits carry the slot index, so no slot ever owns identifier zero. Zero is reserved to mean "value already present".

Top module: `rs_array`

## Requirements
- R1: After reset every slot is free: `full` is 0, `alloc_ready` is 1 and `disp_valid` is 0.
- R2: An accepted allocation fills the lowest-index free slot. `alloc_tag` shows that slot's identifier, {CLASS_ID, index}, where CLASS_ID defaults to 2'b01, giving identifiers 4 to 7. No slot identifier is ever zero.
- R3: `full` is 1 exactly when all slots are occupied. An allocation request made while full changes nothing.
- R4: A source tag of 0 means the accompanying value is valid. A slot allocated with both tags 0 is offered on the dispatch outputs in the cycle after the allocating edge.
- R5: An operand with a nonzero tag holds its slot back until a broadcast carries that tag. The slot then takes the broadcast value and is offered from the next cycle.
- R6: One broadcast wakes every slot waiting on its tag in the same edge. No further broadcast is needed for any of them to dispatch.
- R7: If a broadcast carries the tag of an operand in the same cycle that operand is being allocated, the slot stores the broadcast value at once and treats the operand as present.
- R8: When several slots are ready, the one with the lowest index is offered.
- R9: A slot granted by the execution unit is never offered again while it remains occupied.
- R10: A slot is released only when a broadcast carries its own identifier after it has been granted. Such a broadcast for a slot that has not been granted leaves it occupied.
- R11: A broadcast whose tag matches no waiting operand has no effect on any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue logic requests a slot this cycle |
| alloc_op | input | 4 | Operation code for the new slot |
| alloc_val_a | input | 16 | First operand value (valid when its tag is 0) |
| alloc_tag_a | input | 4 | Producer identifier of the first operand, 0 when present |
| alloc_val_b | input | 16 | Second operand value (valid when its tag is 0) |
| alloc_tag_b | input | 4 | Producer identifier of the second operand, 0 when present |
| alloc_ready | output | 1 | A free slot exists; an allocation would be accepted |
| full | output | 1 | Every slot is occupied; issue must stall |
| alloc_tag | output | 4 | Identifier of the slot the next allocation takes, 0 when full |
| bus_valid | input | 1 | A result is on the broadcast bus |
| bus_tag | input | 4 | Identifier of the slot that produced the result |
| bus_value | input | 16 | Result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_op | output | 4 | Operation of the offered slot |
| disp_a | output | 16 | First operand of the offered slot |
| disp_b | output | 16 | Second operand of the offered slot |
| disp_tag | output | 4 | Identifier of the offered slot |
| disp_grant | input | 1 | Execution unit takes the offered slot at this edge |

## Verification
Two pairs of functions can land in one edge. A broadcast can coincide with the allocation of an operand waiting on the broadcast tag. A broadcast can also release one granted slot while other slots stay waiting or ready. The first case is provoked by driving `alloc_valid` and a matching `bus_valid` together. It is judged by the slot being offered with the broadcast value on the very next cycle, with no second broadcast. The second case is provoked on a full array by broadcasting the identifier of a granted slot. It is judged by `full` falling, by `alloc_tag` naming that slot, and by the next ready slot still being offered unchanged. The same broadcast sent to a slot that has not been granted must leave `full` high.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NUM_ENT = 4;
    localparam int IDX_W   = $clog2(NUM_ENT);
    localparam int CLS_W   = 2;
    localparam int TAG_W   = CLS_W + IDX_W;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 4;

    localparam logic [CLS_W-1:0] CLASS_ADD = 2'd1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    // An operand either carries its value (tag == 0) or waits on a producer.
    typedef struct packed {
        data_t val;
        tag_t  tag;
    } operand_t;

    typedef struct packed {
        logic     busy;
        logic     inflight;
        op_t      op;
        operand_t src_a;
        operand_t src_b;
    } slot_t;

    // Fixed identifier of a slot: class in the upper bits, index below.
    function automatic tag_t make_tag(logic [CLS_W-1:0] cls, int idx);
        return {cls, IDX_W'(idx)};
    endfunction

    // Capture a broadcast result into an operand that waits on it.
    function automatic operand_t snoop(operand_t cur, logic bv, tag_t bt, data_t bd);
        operand_t res;
        res = cur;
        if (cur.tag != '0 && bv && bt == cur.tag) begin
            res.val = bd;
            res.tag = '0;
        end
        return res;
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Lowest index wins: scanning downward leaves the lowest request last.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter tag_t MY_TAG = tag_t'(1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     alloc_en,
    input  op_t      alloc_op,
    input  operand_t alloc_a,
    input  operand_t alloc_b,
    input  logic     bus_valid,
    input  tag_t     bus_tag,
    input  data_t    bus_value,
    input  logic     issue_en,
    output logic     busy,
    output logic     ready,
    output op_t      op_o,
    output data_t    val_a_o,
    output data_t    val_b_o
);
    slot_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (alloc_en) begin
            nxt.busy     = 1'b1;
            nxt.inflight = 1'b0;
            nxt.op       = alloc_op;
            nxt.src_a    = snoop(alloc_a, bus_valid, bus_tag, bus_value);
            nxt.src_b    = snoop(alloc_b, bus_valid, bus_tag, bus_value);
        end else if (cur.busy) begin
            nxt.src_a = snoop(cur.src_a, bus_valid, bus_tag, bus_value);
            nxt.src_b = snoop(cur.src_b, bus_valid, bus_tag, bus_value);
            if (issue_en) begin
                nxt.inflight = 1'b1;
            end
            if (cur.inflight && bus_valid && bus_tag == MY_TAG) begin
                nxt.busy     = 1'b0;
                nxt.inflight = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign busy    = cur.busy;
    assign ready   = cur.busy && !cur.inflight &&
                     cur.src_a.tag == '0 && cur.src_b.tag == '0;
    assign op_o    = cur.op;
    assign val_a_o = cur.src_a.val;
    assign val_b_o = cur.src_b.val;
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter logic [CLS_W-1:0] CLASS_ID = CLASS_ADD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [DATA_W-1:0] alloc_val_a,
    input  logic [TAG_W-1:0]  alloc_tag_a,
    input  logic [DATA_W-1:0] alloc_val_b,
    input  logic [TAG_W-1:0]  alloc_tag_b,
    output logic              alloc_ready,
    output logic              full,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              disp_grant
);
    logic [NUM_ENT-1:0] busy_v, ready_v, free_gnt, disp_gnt;
    logic               any_free;
    op_t                op_v   [NUM_ENT];
    data_t              va_v   [NUM_ENT];
    data_t              vb_v   [NUM_ENT];
    tag_t               tag_v  [NUM_ENT];
    operand_t           new_a, new_b;

    assign new_a = '{val: alloc_val_a, tag: alloc_tag_a};
    assign new_b = '{val: alloc_val_b, tag: alloc_tag_b};

    rs_pick #(.N(NUM_ENT)) i_free_pick (
        .req (~busy_v),
        .gnt (free_gnt),
        .any (any_free)
    );

    rs_pick #(.N(NUM_ENT)) i_disp_pick (
        .req (ready_v),
        .gnt (disp_gnt),
        .any (disp_valid)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        localparam tag_t SLOT_TAG = make_tag(CLASS_ID, g);
        assign tag_v[g] = SLOT_TAG;

        rs_slot #(.MY_TAG(SLOT_TAG)) i_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc_en  (alloc_valid && free_gnt[g]),
            .alloc_op  (alloc_op),
            .alloc_a   (new_a),
            .alloc_b   (new_b),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .issue_en  (disp_gnt[g] && disp_grant),
            .busy      (busy_v[g]),
            .ready     (ready_v[g]),
            .op_o      (op_v[g]),
            .val_a_o   (va_v[g]),
            .val_b_o   (vb_v[g])
        );
    end

    assign full        = !any_free;
    assign alloc_ready = any_free;

    // One-hot selects make the muxes plain AND-OR trees.
    always_comb begin
        alloc_tag = '0;
        disp_op   = '0;
        disp_a    = '0;
        disp_b    = '0;
        disp_tag  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (free_gnt[i]) begin
                alloc_tag = alloc_tag | tag_v[i];
            end
            if (disp_gnt[i]) begin
                disp_op  = disp_op  | op_v[i];
                disp_a   = disp_a   | va_v[i];
                disp_b   = disp_b   | vb_v[i];
                disp_tag = disp_tag | tag_v[i];
            end
        end
    end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk
    import rs_pkg::*;
#(
    parameter logic [CLS_W-1:0] CLASS_ID = CLASS_ADD
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             full,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             disp_valid,
    input logic [TAG_W-1:0] disp_tag,
    input logic             disp_grant
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!disp_valid && !full && alloc_ready));

    // R2
    alloc_tag_class_chk: assert property (@(posedge clk) disable iff (rst)
        !full |-> (alloc_tag[TAG_W-1 -: CLS_W] == CLASS_ID));

    // R2
    disp_tag_class_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_tag[TAG_W-1 -: CLS_W] == CLASS_ID));

    // R3
    full_needs_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(alloc_valid));

    // R9
    no_double_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_grant) |=> !(disp_valid && disp_tag == $past(disp_tag)));
endmodule

bind rs_array rs_array_chk #(.CLASS_ID(CLASS_ID)) i_rs_array_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .full        (full),
    .alloc_tag   (alloc_tag),
    .disp_valid  (disp_valid),
    .disp_tag    (disp_tag),
    .disp_grant  (disp_grant)
);

// File: tb/test_rs_array.sv
`timescale 1ns/1ps
module test_rs_array;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_valid;
    logic [OP_W-1:0]   alloc_op;
    logic [DATA_W-1:0] alloc_val_a, alloc_val_b;
    logic [TAG_W-1:0]  alloc_tag_a, alloc_tag_b;
    logic              alloc_ready, full;
    logic [TAG_W-1:0]  alloc_tag;
    logic              bus_valid;
    logic [TAG_W-1:0]  bus_tag;
    logic [DATA_W-1:0] bus_value;
    logic              disp_valid;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a, disp_b;
    logic [TAG_W-1:0]  disp_tag;
    logic              disp_grant;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rs_array i_rs_array (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_val_a(alloc_val_a), .alloc_tag_a(alloc_tag_a),
        .alloc_val_b(alloc_val_b), .alloc_tag_b(alloc_tag_b),
        .alloc_ready(alloc_ready), .full(full), .alloc_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_tag(disp_tag), .disp_grant(disp_grant)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_op = '0;
        alloc_val_a = '0; alloc_tag_a = '0; alloc_val_b = '0; alloc_tag_b = '0;
        bus_valid = 0; bus_tag = '0; bus_value = '0; disp_grant = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic set_alloc(input int op, input int va, input int ta, input int vb, input int tb);
        alloc_valid = 1; alloc_op = OP_W'(op);
        alloc_val_a = DATA_W'(va); alloc_tag_a = TAG_W'(ta);
        alloc_val_b = DATA_W'(vb); alloc_tag_b = TAG_W'(tb);
    endtask

    task automatic alloc(input int op, input int va, input int ta, input int vb, input int tb);
        set_alloc(op, va, ta, vb, tb);
        tick();
        idle();
    endtask

    task automatic bcast(input int tag, input int val);
        bus_valid = 1; bus_tag = TAG_W'(tag); bus_value = DATA_W'(val);
        tick();
        idle();
    endtask

    task automatic grant();
        disp_grant = 1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 full", full, 0);
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 disp_valid", disp_valid, 0);
        chk("R2 first alloc_tag", alloc_tag, 4);
    endtask

    task automatic t_ready_alloc();
        do_reset();
        alloc(3, 'h11, 0, 'h22, 0);
        chk("R4 disp_valid", disp_valid, 1);
        chk("R4 disp_op", disp_op, 3);
        chk("R4 disp_a", disp_a, 'h11);
        chk("R4 disp_b", disp_b, 'h22);
        chk("R2 disp_tag", disp_tag, 4);
        chk("R2 next alloc_tag", alloc_tag, 5);
    endtask

    task automatic t_wait_wake();
        do_reset();
        alloc(5, 'hdead, 9, 'h33, 0);
        chk("R5 waits", disp_valid, 0);
        bcast(10, 'haa);
        chk("R11 foreign tag", disp_valid, 0);
        bcast(9, 'h1234);
        chk("R5 woken", disp_valid, 1);
        chk("R5 captured a", disp_a, 'h1234);
        chk("R5 kept b", disp_b, 'h33);
    endtask

    task automatic t_multi_wake();
        do_reset();
        alloc(1, 0, 12, 1, 0);
        alloc(2, 0, 12, 2, 0);
        alloc(3, 0, 12, 3, 0);
        chk("R6 all waiting", disp_valid, 0);
        bcast(12, 'h50);
        chk("R6 woken", disp_valid, 1);
        chk("R8 lowest first", disp_tag, 4);
        chk("R6 value", disp_a, 'h50);
        grant();
        chk("R9 next slot", disp_tag, 5);
        chk("R6 second op", disp_op, 2);
        grant();
        chk("R9 third slot", disp_tag, 6);
        chk("R6 third value", disp_a, 'h50);
        grant();
        chk("R9 none left", disp_valid, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 1; k <= 4; k++) alloc(k, 0, 9, k, 0);
        chk("R3 full", full, 1);
        chk("R3 alloc_ready", alloc_ready, 0);
        chk("R3 alloc_tag", alloc_tag, 0);
        alloc(7, 'h1, 0, 'h2, 0);
        chk("R3 ignored alloc", disp_valid, 0);
        bcast(5, 0);
        chk("R10 not granted stays", full, 1);
        bcast(9, 'h77);
        chk("R3 wake", disp_tag, 4);
        chk("R3 value", disp_a, 'h77);
        grant();
        chk("R10 still full", full, 1);
        bcast(4, 'h99);
        chk("R10 released", full, 0);
        chk("R10 free slot", alloc_tag, 4);
        chk("R10 others intact", disp_tag, 5);
    endtask

    task automatic t_bypass();
        do_reset();
        set_alloc(6, 'hffff, 13, 'h5, 0);
        bus_valid = 1; bus_tag = 13; bus_value = 'h4242;
        tick();
        idle();
        chk("R7 ready", disp_valid, 1);
        chk("R7 captured", disp_a, 'h4242);
        chk("R7 op", disp_op, 6);
    endtask

    task automatic t_lowest();
        do_reset();
        alloc(1, 0, 9, 0, 0);
        alloc(2, 'hb, 0, 'hc, 0);
        alloc(3, 'hd, 0, 'he, 0);
        chk("R8 lowest ready", disp_tag, 5);
        bcast(9, 'h1);
        chk("R8 lower woken", disp_tag, 4);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle();
        t_reset();
        t_ready_alloc();
        t_wait_wake();
        t_multi_wake();
        t_full();
        t_bypass();
        t_lowest();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule